// File: doc/BRIEF.md
# Serial Frame Buffer Port

This block lets a host controller read and write the 128-byte frame memory of a radio transceiver over a four-wire serial link. A transaction opens when the host pulls the select line low and closes when select goes high again. Inside a transaction, the first byte chooses a direction and the second byte sets where in the memory to begin. Every byte after that is payload. It is written into the memory or returned to the host, and the memory pointer moves on by one after each payload byte. A host can patch a few bytes of a stored frame in place this way, or fetch one status byte, without moving the whole frame.

All serial inputs are brought into the block's own clock domain through synchronizer stages, and edges of the serial clock are found there. SCLK high and low phases must each last at least four system clock cycles. The serial link uses mode 0: the host launches data on the falling edge and both sides sample on the rising edge. Bytes travel most significant bit first. A second, read-only port on the memory gives the radio side access to the stored bytes.

Top module: `spi_fb_access`

## Requirements
- R1: While select is high, MISO is 0 and the memory is never written. Raising select returns the block to waiting for a command byte.
- R2: The command is decoded from its top three bits only. 010 selects memory write and 000 selects memory read. The low five bits have no effect.
- R3: Any other top-three-bit code makes the rest of that transaction ignored. No memory location is written, and MISO stays 0 until select goes high.
- R4: The second byte sets the start address from its low seven bits. Bit 7 is ignored.
- R5: In a write transaction, each complete byte from the third byte onward is stored at the current address.
- R6: In a read transaction, the byte at the current address is shifted out on MISO during the third and each later byte, MSB first. Its MSB is already on MISO before the first rising SCLK edge of that byte.
- R7: The address advances by one after every payload byte, for any number of payload bytes.
- R8: An advance from address 0x7F wraps to 0x00.
- R9: A payload byte that select cuts off before all eight bits arrive is discarded and writes nothing.
- R10: MISO is 0 during the command and address bytes. MOSI content during read payload bytes has no effect on the memory.
- R11: MISO changes only after a falling SCLK edge, after a read-data load at a byte boundary, or when select rises.
- R12: The radio-side read port returns the byte at its address one clock cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (registered) |
| buf_raddr | input | ADDR_W (7) | Radio-side read address |
| buf_rdata | output | DATA_W (8) | Radio-side read data, one cycle after the address |

## Verification
The bench builds the block with its defaults: 8-bit bytes, a 7-bit address and two synchronizer stages. This makes the full 128-byte space small enough that bursts can start at 0x7E and 0x7F to exercise the wrap into 0x00. It also leaves enough room between SCLK edges that the read prefetch must land before the MSB is sampled. The radio-side port gives an independent view of every byte written. That view shows that rejected commands, read transactions and truncated bytes leave memory unchanged.

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_t;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_READ} op_t;
  localparam int CMD_BITS = 3;
  localparam logic [CMD_BITS-1:0] CMD_WRITE = 3'b010;
  localparam logic [CMD_BITS-1:0] CMD_READ  = 3'b000;
endpackage

// File: rtl/spi_fb_sync.sv
module spi_fb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic cs_q,
  output logic mosi_q,
  output logic sclk_rise,
  output logic sclk_fall
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] cs_sh, sclk_sh, mosi_sh;
  logic         sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sh   <= '1;
      sclk_sh <= '0;
      mosi_sh <= '0;
      sclk_d  <= 1'b0;
    end else begin
      cs_sh   <= {cs_sh[TOP-1:0], cs_n};
      sclk_sh <= {sclk_sh[TOP-1:0], sclk};
      mosi_sh <= {mosi_sh[TOP-1:0], mosi};
      sclk_d  <= sclk_sh[TOP];
    end
  end

  assign cs_q      = cs_sh[TOP];
  assign mosi_q    = mosi_sh[TOP];
  assign sclk_rise = sclk_sh[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_sh[TOP] & sclk_d;
endmodule

// File: rtl/spi_fb_ctrl.sv
module spi_fb_ctrl
  import spi_fb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_q,
  input  logic              mosi_q,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              tx_load,
  output logic              miso
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh, rx_next, tx_sh;
  logic [ADDR_W-1:0] addr_cnt;
  phase_t            phase;
  op_t               op, dec_op;
  logic              byte_done;

  assign rx_next   = {rx_sh[DATA_W-2:0], mosi_q};
  assign byte_done = !cs_q && sclk_rise && (bit_cnt == LAST_BIT);

  always_comb begin
    case (rx_next[DATA_W-1 -: CMD_BITS])
      CMD_WRITE: dec_op = OP_WRITE;
      CMD_READ:  dec_op = OP_READ;
      default:   dec_op = OP_NONE;
    endcase
  end

  assign ram_we    = byte_done && (phase == PH_DATA) && (op == OP_WRITE);
  assign ram_re    = byte_done && (op == OP_READ) &&
                     ((phase == PH_ADDR) || (phase == PH_DATA));
  assign ram_addr  = (phase == PH_ADDR) ? rx_next[ADDR_W-1:0] : addr_cnt;
  assign ram_wdata = rx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_cnt <= '0;
    end else if (byte_done) begin
      if (phase == PH_ADDR)
        addr_cnt <= (op == OP_READ) ? rx_next[ADDR_W-1:0] + 1'b1
                                    : rx_next[ADDR_W-1:0];
      else if (phase == PH_DATA && op != OP_NONE)
        addr_cnt <= addr_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_q) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      tx_load <= 1'b0;
      phase   <= PH_CMD;
      op      <= OP_NONE;
    end else begin
      tx_load <= ram_re;
      if (sclk_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            op    <= dec_op;
            phase <= PH_ADDR;
          end
          PH_ADDR: phase <= PH_DATA;
          default: phase <= PH_DATA;
        endcase
      end
      if (tx_load)
        tx_sh <= ram_rdata;
      else if (sclk_fall && bit_cnt != '0)
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  assign miso = tx_sh[DATA_W-1];
endmodule

// File: rtl/spi_fb_ram.sv
module spi_fb_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we)
      mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/spi_fb_access.sv
module spi_fb_access #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] buf_raddr,
  output logic [DATA_W-1:0] buf_rdata
);
  logic              cs_q, mosi_q, sclk_rise, sclk_fall;
  logic              ram_we, ram_re, tx_load;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  spi_fb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .cs_q      (cs_q),
    .mosi_q    (mosi_q),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall)
  );

  spi_fb_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_q      (cs_q),
    .mosi_q    (mosi_q),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .ram_rdata (ram_rdata),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .tx_load   (tx_load),
    .miso      (spi_miso)
  );

  spi_fb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk     (clk),
    .a_we    (ram_we),
    .a_addr  (ram_addr),
    .a_wdata (ram_wdata),
    .a_rdata (ram_rdata),
    .b_addr  (buf_raddr),
    .b_rdata (buf_rdata)
  );
endmodule

// File: rtl/spi_fb_access_chk.sv
module spi_fb_access_chk (
  input logic clk,
  input logic rst,
  input logic cs_q,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic ram_we,
  input logic ram_re,
  input logic tx_load,
  input logic spi_miso
);
  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !spi_miso); // R1

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_q |-> !ram_we); // R1

  AST_WRITE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> sclk_rise); // R9

  AST_READ_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    ram_re |-> (sclk_rise && !cs_q)); // R6

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re)); // R5

  AST_MISO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_miso) |-> ($past(sclk_fall) || $past(tx_load) || $past(cs_q))); // R11
endmodule

bind spi_fb_access spi_fb_access_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_q      (cs_q),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .tx_load   (tx_load),
  .spi_miso  (spi_miso)
);

// File: tb/spi_fb_access_test.sv
module spi_fb_access_test;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic [6:0] raddr = '0;
  logic [7:0] rdata;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic [7:0] model [128];

  always #4 clk = ~clk;

  spi_fb_access uut (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (cs_n),
    .spi_sclk  (sclk),
    .spi_mosi  (mosi),
    .spi_miso  (miso),
    .buf_raddr (raddr),
    .buf_rdata (rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic peek(input logic [6:0] a, output logic [7:0] d);
    raddr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic burst_write(input logic [7:0] cmd, input logic [7:0] adr,
                             input logic [7:0] d0, input int n);
    logic [7:0] rx;
    sel();
    xfer(cmd, rx);
    xfer(adr, rx);
    for (int k = 0; k < n; k++) begin
      xfer(d0 + 8'(k * 17), rx);
      model[7'(adr[6:0] + 7'(k))] = d0 + 8'(k * 17);
    end
    desel();
  endtask

  task automatic t_reset();
    chk("R1 reset miso", {7'd0, miso}, 8'h00);
  endtask

  task automatic t_write_burst();
    logic [7:0] d;
    burst_write(8'h40, 8'h10, 8'h3C, 5);
    for (int k = 0; k < 5; k++) begin
      peek(7'h10 + 7'(k), d);
      chk($sformatf("R5 R7 R12 write burst addr %0d", 16 + k), d, model[7'h10 + 7'(k)]);
    end
  endtask

  task automatic t_read_burst();
    logic [7:0] rx, d;
    sel();
    xfer(8'h00, rx);
    chk("R10 miso during command", rx, 8'h00);
    xfer(8'h10, rx);
    chk("R10 miso during address", rx, 8'h00);
    for (int k = 0; k < 5; k++) begin
      xfer(8'hFF, rx);
      chk($sformatf("R6 R7 R11 read burst byte %0d", k), rx, model[7'h10 + 7'(k)]);
    end
    desel();
    chk("R1 miso low after release", {7'd0, miso}, 8'h00);
    for (int k = 0; k < 5; k++) begin
      peek(7'h10 + 7'(k), d);
      chk("R10 mosi ignored during read", d, model[7'h10 + 7'(k)]);
    end
  endtask

  task automatic t_wrap_write();
    logic [7:0] d;
    burst_write(8'h5F, 8'hFE, 8'hA1, 3);
    peek(7'h7E, d); chk("R2 R4 write start 0x7E", d, model[7'h7E]);
    peek(7'h7F, d); chk("R7 write 0x7F", d, model[7'h7F]);
    peek(7'h00, d); chk("R8 write wrap 0x00", d, model[7'h00]);
  endtask

  task automatic t_wrap_read();
    logic [7:0] rx;
    sel();
    xfer(8'h1F, rx);
    xfer(8'h7F, rx);
    xfer(8'h00, rx); chk("R2 read low bits ignored", rx, model[7'h7F]);
    xfer(8'h00, rx); chk("R8 read wrap", rx, model[7'h00]);
    desel();
  endtask

  task automatic t_bad_cmd();
    logic [7:0] rx, d;
    sel();
    xfer(8'hE0, rx);
    xfer(8'h10, rx);
    xfer(8'h11, rx); chk("R3 miso after bad cmd", rx, 8'h00);
    xfer(8'h22, rx); chk("R3 miso after bad cmd 2", rx, 8'h00);
    desel();
    peek(7'h10, d); chk("R3 no write 0x10", d, model[7'h10]);
    peek(7'h11, d); chk("R3 no write 0x11", d, model[7'h11]);
  endtask

  task automatic t_partial();
    logic [7:0] rx, d;
    burst_write(8'h40, 8'h20, 8'h01, 2);
    sel();
    xfer(8'h40, rx);
    xfer(8'h20, rx);
    xfer(8'h33, rx);
    model[7'h20] = 8'h33;
    xfer_bits(8'hCC, 4);
    desel();
    peek(7'h20, d); chk("R9 full byte kept", d, 8'h33);
    peek(7'h21, d); chk("R9 partial byte dropped", d, model[7'h21]);
  endtask

  task automatic t_single();
    logic [7:0] rx, d;
    burst_write(8'h40, 8'h45, 8'h96, 1);
    peek(7'h45, d); chk("R5 single byte write", d, 8'h96);
    peek(7'h46, d); chk("R7 single write no spill", d, model[7'h46]);
    sel();
    xfer(8'h00, rx);
    xfer(8'h45, rx);
    xfer(8'h00, rx); chk("R6 single byte read", rx, 8'h96);
    desel();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    t_reset();
    burst_write(8'h40, 8'h00, 8'h00, 0);
    for (int i = 0; i < 128; i += 16) begin
      sel();
      begin
        logic [7:0] rx;
        xfer(8'h40, rx);
        xfer(8'(i), rx);
        for (int k = 0; k < 16; k++) xfer(8'h00, rx);
      end
      desel();
    end
    t_write_burst();
    t_read_burst();
    t_wrap_write();
    t_wrap_read();
    t_bad_cmd();
    t_partial();
    t_single();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule